// File: doc/BRIEF.md
# Password Retry Lockout Controller

This block counts wrong password attempts for a password-protected memory and locks the part once too many have been made. A separate comparator reports each attempt through a strobe that carries three things: whether the password matched, whether it was a reset-class password, and which reset command it came with. The block produces four outputs. The first is a lock level, which makes every read or write password comparison fail. The second is a one-cycle request to wipe all storage arrays. The third is a one-cycle request to zero every stored password. The fourth is a one-cycle grant for each accepted password.

The failure counter survives a set number of wrong attempts. The next failure after that locks the part and requests one array wipe. The stored passwords are left as they are. Once the part is locked, the counter freezes and only a reset-class password can act. If it comes with the reset-device command, it unlocks the part and restarts the count. If it comes with the reset-password command, it requests both the wipe and the password zeroing.

Top module: `pw_lockout_ctrl`

## Requirements
- R1: After reset, `locked`, `wipe_req`, `zero_req` and `grant` are 0 and the failure count is zero.
- R2: With `MAX_TRIES` = 8, eight consecutive failed strobes leave `locked` at 0 with no wipe. The ninth sets `locked` and raises `wipe_req`, both in the cycle after that strobe.
- R3: A strobe with `verify_ok` = 0 counts as a failure whatever the password type, including `pw_is_reset` = 1.
- R4: A strobe with `verify_ok` = 1 while unlocked raises `grant` for one cycle and restarts the failure count from zero.
- R5: While locked, a matching non-reset password gives no `grant`. `locked` stays at 1 unless a reset-device unlock arrives. Further failures do not wrap the count and raise no new wipe.
- R6: The lockout wipe never raises `zero_req`.
- R7: A matching reset-class password with `cmd_reset_dev` = 1 raises `grant`, clears `locked`, and zeroes the count. It raises neither `wipe_req` nor `zero_req`. It acts the same way when the part is not locked.
- R8: A matching reset-class password with `cmd_reset_pw` = 1 raises `wipe_req`, `zero_req` and `grant` together for one cycle, whether or not the part is locked. It restarts the count when unlocked and leaves `locked` unchanged.
- R9: `wipe_req`, `zero_req` and `grant` are registered pulses. They appear only in the cycle after a strobe and are 0 in the cycle after a cycle without one.
- R10: Without `verify_vld`, the other strobe inputs have no effect on any output or on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| verify_vld | input | 1 | One-cycle strobe: a password comparison finished |
| verify_ok | input | 1 | Comparison matched (valid with strobe) |
| pw_is_reset | input | 1 | The compared password is reset-class |
| cmd_reset_dev | input | 1 | Attempt belongs to a reset-device command |
| cmd_reset_pw | input | 1 | Attempt belongs to a reset-password command |
| locked | output | 1 | Lockout level; read/write matches are rejected |
| wipe_req | output | 1 | One-cycle request to clear all arrays |
| zero_req | output | 1 | One-cycle request to zero all passwords |
| grant | output | 1 | One-cycle access grant for an accepted password |

## Verification
The bench builds the block with `MAX_TRIES` left at its default of 8. With that limit, the ninth-failure overflow is only nine strobes deep, so a random run with a low match rate locks the part many times over. The same run also reaches every command mix while the part is locked. Directed runs of exactly eight and nine failures pin down the boundary on both sides. They do this after reset, after a grant and after each kind of reset command.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

    // Classified outcome of one verify strobe
    typedef struct packed {
        logic fail;     // attempt rejected
        logic pass;     // attempt accepted
        logic unlock;   // accepted reset-class password with reset-device
        logic wipe;     // accepted reset-class password with reset-password
        logic zero_pw;  // same condition, password zeroing
    } attempt_t;

    function automatic int unsigned cnt_width(input int unsigned tries);
        return $clog2(tries + 1);
    endfunction

    function automatic attempt_t classify(
        input logic vld,
        input logic ok,
        input logic is_rst,
        input logic dev,
        input logic rpw,
        input logic locked
    );
        attempt_t a;
        a = '0;
        if (vld) begin
            if (ok && (is_rst || !locked)) begin
                a.pass    = 1'b1;
                a.unlock  = is_rst && dev;
                a.wipe    = is_rst && rpw;
                a.zero_pw = is_rst && rpw;
            end else begin
                a.fail = 1'b1;
            end
        end
        return a;
    endfunction

endpackage

// File: rtl/pwl_attempt_decode.sv
module pwl_attempt_decode
    import pwl_pkg::*;
(
    input  logic     verify_vld,
    input  logic     verify_ok,
    input  logic     pw_is_reset,
    input  logic     cmd_reset_dev,
    input  logic     cmd_reset_pw,
    input  logic     locked,
    output attempt_t ev
);

    always_comb begin
        ev = classify(verify_vld, verify_ok, pw_is_reset,
                      cmd_reset_dev, cmd_reset_pw, locked);
    end

endmodule

// File: rtl/pwl_try_counter.sv
module pwl_try_counter
    import pwl_pkg::*;
#(
    parameter int unsigned MAX_TRIES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fail,
    input  logic pass,
    input  logic unlock,
    output logic locked,
    output logic overflow
);

    localparam int unsigned CNT_W = cnt_width(MAX_TRIES);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_TRIES);

    logic [CNT_W-1:0] cnt_q;
    logic             lock_q;

    // Failure past the tolerated count while still armed
    assign overflow = fail && !lock_q && (cnt_q == LIMIT);
    assign locked   = lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else if (unlock) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else if (!lock_q) begin
            if (pass) begin
                cnt_q <= '0;
            end else if (overflow) begin
                lock_q <= 1'b1;
            end else if (fail) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pwl_action_regs.sv
module pwl_action_regs
    import pwl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  attempt_t ev,
    input  logic     overflow,
    output logic     wipe_req,
    output logic     zero_req,
    output logic     grant
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wipe_req <= 1'b0;
            zero_req <= 1'b0;
            grant    <= 1'b0;
        end else begin
            wipe_req <= overflow || ev.wipe;
            zero_req <= ev.zero_pw;
            grant    <= ev.pass;
        end
    end

endmodule

// File: rtl/pw_lockout_ctrl.sv
module pw_lockout_ctrl
    import pwl_pkg::*;
#(
    parameter int unsigned MAX_TRIES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic verify_vld,
    input  logic verify_ok,
    input  logic pw_is_reset,
    input  logic cmd_reset_dev,
    input  logic cmd_reset_pw,
    output logic locked,
    output logic wipe_req,
    output logic zero_req,
    output logic grant
);

    attempt_t ev;
    logic     overflow;
    logic     lock_lvl;

    pwl_attempt_decode u_dec (
        .verify_vld    (verify_vld),
        .verify_ok     (verify_ok),
        .pw_is_reset   (pw_is_reset),
        .cmd_reset_dev (cmd_reset_dev),
        .cmd_reset_pw  (cmd_reset_pw),
        .locked        (lock_lvl),
        .ev            (ev)
    );

    pwl_try_counter #(.MAX_TRIES(MAX_TRIES)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .fail     (ev.fail),
        .pass     (ev.pass),
        .unlock   (ev.unlock),
        .locked   (lock_lvl),
        .overflow (overflow)
    );

    pwl_action_regs u_act (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .overflow (overflow),
        .wipe_req (wipe_req),
        .zero_req (zero_req),
        .grant    (grant)
    );

    assign locked = lock_lvl;

endmodule

// File: rtl/pwl_lockout_chk.sv
module pwl_lockout_chk (
    input logic clk,
    input logic rst,
    input logic verify_vld,
    input logic verify_ok,
    input logic pw_is_reset,
    input logic cmd_reset_dev,
    input logic cmd_reset_pw,
    input logic locked,
    input logic wipe_req,
    input logic zero_req,
    input logic grant
);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !verify_vld |=> (!wipe_req && !zero_req && !grant));

    // R2
    lock_wipes_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> wipe_req);

    // R5
    locked_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && verify_vld && !pw_is_reset) |=> !grant);

    // R5
    lock_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && !(verify_vld && verify_ok && pw_is_reset && cmd_reset_dev))
        |=> locked);

    // R7
    unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (verify_vld && verify_ok && pw_is_reset && cmd_reset_dev) |=> !locked);

    // R6
    zero_only_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !(verify_vld && verify_ok && pw_is_reset && cmd_reset_pw) |=> !zero_req);

    // R8
    zero_on_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (verify_vld && verify_ok && pw_is_reset && cmd_reset_pw)
        |=> (zero_req && wipe_req && grant));

endmodule

bind pw_lockout_ctrl pwl_lockout_chk chk_i (.*);

// File: tb/pw_lockout_ctrl_tb_top.sv
`timescale 1ns/1ps
module pw_lockout_ctrl_tb_top;

    localparam int TRIES = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vld = 1'b0, ok = 1'b0, isr = 1'b0, dev = 1'b0, rpw = 1'b0;
    logic locked, wipe, zero, grant;

    int n_run  = 0;
    int n_fail = 0;

    int m_cnt  = 0;
    bit m_lock = 1'b0;
    bit e_wipe = 1'b0, e_zero = 1'b0, e_grant = 1'b0;

    always #10 clk = ~clk;

    pw_lockout_ctrl #(.MAX_TRIES(TRIES)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .verify_vld    (vld),
        .verify_ok     (ok),
        .pw_is_reset   (isr),
        .cmd_reset_dev (dev),
        .cmd_reset_pw  (rpw),
        .locked        (locked),
        .wipe_req      (wipe),
        .zero_req      (zero),
        .grant         (grant)
    );

    task automatic chk(input string tag, input string what, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    // Expected behaviour from the requirements
    task automatic model(input bit v, input bit o, input bit r, input bit d, input bit p);
        e_wipe = 0; e_zero = 0; e_grant = 0;
        if (v) begin
            if (o && (r || !m_lock)) begin
                e_grant = 1;
                if (r && d) begin
                    m_cnt = 0; m_lock = 0;
                end else if (!m_lock) begin
                    m_cnt = 0;
                end
                if (r && p) begin
                    e_wipe = 1; e_zero = 1;
                end
            end else if (!m_lock) begin
                if (m_cnt == TRIES) begin
                    m_lock = 1; e_wipe = 1;
                end else begin
                    m_cnt++;
                end
            end
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "locked", locked, m_lock);
        chk(tag, "wipe_req", wipe, e_wipe);
        chk(tag, "zero_req", zero, e_zero);
        chk(tag, "grant", grant, e_grant);
    endtask

    // Entered and left at a falling edge
    task automatic step(input string tag, input bit v, input bit o, input bit r,
                        input bit d, input bit p);
        vld = v; ok = o; isr = r; dev = d; rpw = p;
        model(v, o, r, d, p);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic fails(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1, 0, (i % 3 == 0), 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2417));
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all("R1");
        rst = 1'b0;
        step("R1", 0, 0, 0, 0, 0);

        // R2 / R3: eight failures tolerated, ninth locks, no password zeroing (R6)
        fails("R3", TRIES);
        step("R2", 1, 0, 1, 0, 0);
        chk("R6", "zero_req on lock", zero, 1'b0);
        step("R9", 0, 0, 0, 0, 0);

        // R5: locked rejects read/write match, counter frozen
        step("R5", 1, 1, 0, 0, 0);
        fails("R5", 12);

        // R8 while locked
        step("R8", 1, 1, 1, 0, 1);
        step("R9", 0, 0, 0, 0, 0);

        // R7 unlock, then count restarted
        step("R7", 1, 1, 1, 1, 0);
        fails("R7", TRIES);
        // R4: grant restarts the count; exactly nine more failures lock
        step("R4", 1, 1, 0, 0, 0);
        fails("R4", TRIES);
        step("R4", 1, 0, 0, 0, 0);

        // R7 unlock, reset-device before overflow only clears the count
        step("R7", 1, 1, 1, 1, 0);
        fails("R7", 5);
        step("R7", 1, 1, 1, 1, 0);
        fails("R7", TRIES);
        step("R7", 1, 0, 0, 0, 0);
        step("R7", 1, 1, 1, 1, 0);

        // R10: command lines without strobe do nothing
        fails("R10", 7);
        step("R10", 0, 1, 1, 1, 1);
        step("R10", 0, 1, 0, 0, 1);
        step("R10", 1, 0, 0, 0, 0);
        step("R10", 1, 0, 0, 0, 0);

        // R8 while unlocked restarts the count
        step("R7", 1, 1, 1, 1, 0);
        fails("R8", 6);
        step("R8", 1, 1, 1, 0, 1);
        fails("R8", TRIES);
        step("R8", 1, 0, 0, 0, 0);

        // Random mix
        for (int i = 0; i < 1500; i++) begin
            step("R9", ($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 3) == 0,
                 ($urandom % 4) == 0, ($urandom % 6) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule